// File: doc/BRIEF.md
# Storage Controller Enable and Configuration Register File

This block is the memory-mapped control register file that sits in front of a queue-based storage controller. Host software reaches it through a simple dword register port. It holds a read-only capability and version pair, an interrupt mask with separate set and clear addresses, a configuration word, a status word, the admin queue size word and the two 64-bit admin queue base addresses.

Its main job is the start and stop handshake. When software raises the enable bit, the block checks the programmed configuration against its own capability limits in the same cycle. It then reports either ready or a fatal configuration error. On success it latches the parameters the queue engine needs: page size, entry sizes, admin queue depths and base addresses. Dropping enable, or raising the shutdown request field, tears the queues down. The block signals this with a one-cycle teardown pulse. The shutdown request has its own completion status, kept apart from the enable state.

Top module: `hostctl_regs`

## Requirements
- R1: After reset every writable register and the status word read zero; the capability reads 0x0F0107FF at offset 0x00 and 0x00400020 at offset 0x04 (entry limit 0x7FF in bits 15:0, contiguous-queue flag bit 16, timeout 0xF in bits 31:24, command set 1 at bit 37, page field min 0 in bits 51:48 and max 4 in bits 55:52); the version at 0x08 reads 0x00010001.
- R2: A write to 0x0C ORs the data into the interrupt mask; a write to 0x10 clears the bits that are set in the data; both offsets read the mask, which is also driven on `irq_mask`.
- R3: A write to the low dword of a queue base (0x28 submission, 0x30 completion) replaces the full 64-bit base with the zero-extended data; a write to the high dword (0x2C, 0x34) ORs the data into bits 63:32.
- R4: When a configuration write (0x14) takes enable (bit 0) from 0 to 1 and the configuration is valid, status bit 0 (ready) is set, bit 1 is cleared and `queues_live` rises. The outputs then carry the following latched values: page bits = page field (bits 10:7) + 12, page size = 2^page bits, submission and completion entry bytes = 2^(bits 19:16) and 2^(bits 23:20), admin depths = the size word fields (submission bits 11:0, completion bits 27:16) plus one, and the two bases.
- R5: The enable edge fails if any of these holds: the admin queues are already live, either base is zero, the page field is outside 0..4, the submission entry field is not 6, the completion entry field is not 4, or either size field is zero. On failure the status word becomes exactly bit 1 (fatal), ready stays 0 and nothing is latched.
- R6: Base alignment is judged against the page size being programmed, so a base aligned to 4 KiB but not 8 KiB passes with page field 0 and fails with page field 1.
- R7: A configuration write that takes enable from 1 to 0 clears the configuration word to zero, clears ready, drops `queues_live` and pulses `queue_teardown` for one cycle; the fatal bit is left as it was.
- R8: A configuration write whose shutdown field (bits 15:14) goes from zero to nonzero stores the written word, tears the queues down (teardown pulse, `queues_live` low) and sets the shutdown status field (bits 3:2) to 2. A later write that returns the field to zero stores the word and clears bits 3:2.
- R9: A configuration write that changes neither the enable bit nor the zero/nonzero state of the shutdown field leaves the configuration word unchanged.
- R10: Read data appears on `rdata` the cycle after `rd_en`; offsets that hold no register, including every offset from 0x38 up, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the dword accessed (bits 1:0 ignored) |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, one cycle after rd_en |
| irq_mask | output | 32 | Current interrupt mask |
| hc_ready | output | 1 | Status ready bit |
| hc_fatal | output | 1 | Status fatal configuration bit |
| shdn_done | output | 1 | Shutdown complete indication |
| queues_live | output | 1 | Admin queues created and active |
| queue_teardown | output | 1 | One-cycle pulse when queues are torn down |
| page_bits | output | 5 | Latched log2 of page size |
| page_size | output | 32 | Latched page size in bytes |
| sq_entry_bytes | output | 16 | Latched submission entry size |
| cq_entry_bytes | output | 16 | Latched completion entry size |
| admin_sq_depth | output | 13 | Latched admin submission queue depth |
| admin_cq_depth | output | 13 | Latched admin completion queue depth |
| admin_sq_base | output | 64 | Latched admin submission base |
| admin_cq_base | output | 64 | Latched admin completion base |

## Verification
The enable edge is tried first with a zero size word and then with a fully valid setup. Both the 4 KiB and 8 KiB page settings are used over a base aligned only to 4 KiB, which separates alignment taken from the programmed page field from a fixed 4 KiB test. Each remaining failure cause is applied on its own: a page field above the limit, wrong entry sizes, and a zero base. A failure that leaks through shows up as ready instead of fatal. Shutdown is raised while enabled, rewritten without a state change, and cleared, so the shutdown path is kept apart from the enable path and from plain rewrites of the configuration word.

// File: rtl/hostctl_pkg.sv
package hostctl_pkg;

    // dword indices of the register file; the offsets are what software decodes
    localparam int WORD_CAP_LO = 0;
    localparam int WORD_CAP_HI = 1;
    localparam int WORD_VER    = 2;
    localparam int WORD_MSET   = 3;
    localparam int WORD_MCLR   = 4;
    localparam int WORD_CFG    = 5;
    localparam int WORD_STS    = 7;
    localparam int WORD_ATTR   = 9;
    localparam int WORD_SQB_LO = 10;
    localparam int WORD_SQB_HI = 11;
    localparam int WORD_CQB_LO = 12;
    localparam int WORD_CQB_HI = 13;

    localparam logic [31:0] VERSION_WORD = 32'h0001_0001;
    localparam logic [1:0]  SHST_DONE    = 2'b10;

    typedef struct packed {
        logic [1:0] shst;
        logic       fatal;
        logic       ready;
    } status_t;

    typedef struct packed {
        logic [4:0]  pg_bits;
        logic [3:0]  sqes;
        logic [3:0]  cqes;
        logic [11:0] asqs;
        logic [11:0] acqs;
        logic [63:0] sq_base;
        logic [63:0] cq_base;
    } live_cfg_t;

    function automatic logic f_en(input logic [31:0] c);
        return c[0];
    endfunction

    function automatic logic [3:0] f_mps(input logic [31:0] c);
        return c[10:7];
    endfunction

    function automatic logic [1:0] f_shn(input logic [31:0] c);
        return c[15:14];
    endfunction

    function automatic logic [3:0] f_sqes(input logic [31:0] c);
        return c[19:16];
    endfunction

    function automatic logic [3:0] f_cqes(input logic [31:0] c);
        return c[23:20];
    endfunction

    function automatic logic [11:0] f_asqs(input logic [31:0] a);
        return a[11:0];
    endfunction

    function automatic logic [11:0] f_acqs(input logic [31:0] a);
        return a[27:16];
    endfunction

endpackage

// File: rtl/hostctl_cfg_check.sv
module hostctl_cfg_check
    import hostctl_pkg::*;
#(
    parameter int MPS_MIN  = 0,
    parameter int MPS_MAX  = 4,
    parameter int SQES_MIN = 6,
    parameter int SQES_MAX = 6,
    parameter int CQES_MIN = 4,
    parameter int CQES_MAX = 4
) (
    input  logic [31:0] cfg_word,
    input  logic [31:0] attr_word,
    input  logic [63:0] sq_base,
    input  logic [63:0] cq_base,
    input  logic        queues_live,
    output logic        cfg_ok,
    output logic [4:0]  pg_bits
);
    logic [3:0]  mps;
    logic [3:0]  sqes;
    logic [3:0]  cqes;
    logic [63:0] pg_mask;
    logic        base_ok;
    logic        field_ok;
    logic        size_ok;

    always_comb begin
        mps      = f_mps(cfg_word);
        sqes     = f_sqes(cfg_word);
        cqes     = f_cqes(cfg_word);
        pg_bits  = 5'd12 + {1'b0, mps};
        pg_mask  = (64'd1 << pg_bits) - 64'd1;
        base_ok  = (sq_base != 64'd0) && (cq_base != 64'd0) &&
                   ((sq_base & pg_mask) == 64'd0) && ((cq_base & pg_mask) == 64'd0);
        field_ok = (int'(mps)  >= MPS_MIN)  && (int'(mps)  <= MPS_MAX) &&
                   (int'(sqes) >= SQES_MIN) && (int'(sqes) <= SQES_MAX) &&
                   (int'(cqes) >= CQES_MIN) && (int'(cqes) <= CQES_MAX);
        size_ok  = (f_asqs(attr_word) != 12'd0) && (f_acqs(attr_word) != 12'd0);
        cfg_ok   = !queues_live && base_ok && field_ok && size_ok;
    end
endmodule

// File: rtl/hostctl_rd_mux.sv
module hostctl_rd_mux
    import hostctl_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic [WORD_W-1:0] word,
    input  logic [63:0]       cap,
    input  logic [31:0]       mask,
    input  logic [31:0]       cfg,
    input  status_t           sts,
    input  logic [31:0]       attr,
    input  logic [63:0]       sq_base,
    input  logic [63:0]       cq_base,
    output logic [31:0]       data
);
    always_comb begin
        case (int'(word))
            WORD_CAP_LO: data = cap[31:0];
            WORD_CAP_HI: data = cap[63:32];
            WORD_VER:    data = VERSION_WORD;
            WORD_MSET,
            WORD_MCLR:   data = mask;
            WORD_CFG:    data = cfg;
            WORD_STS:    data = {28'd0, sts};
            WORD_ATTR:   data = attr;
            WORD_SQB_LO: data = sq_base[31:0];
            WORD_SQB_HI: data = sq_base[63:32];
            WORD_CQB_LO: data = cq_base[31:0];
            WORD_CQB_HI: data = cq_base[63:32];
            default:     data = 32'd0;
        endcase
    end
endmodule

// File: rtl/hostctl_regs.sv
module hostctl_regs
    import hostctl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int MQES     = 16'h07FF,
    parameter int TIMEOUT  = 8'h0F,
    parameter int MPS_MIN  = 0,
    parameter int MPS_MAX  = 4,
    parameter int SQES_MIN = 6,
    parameter int SQES_MAX = 6,
    parameter int CQES_MIN = 4,
    parameter int CQES_MAX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    output logic [31:0]       irq_mask,
    output logic              hc_ready,
    output logic              hc_fatal,
    output logic              shdn_done,
    output logic              queues_live,
    output logic              queue_teardown,
    output logic [4:0]        page_bits,
    output logic [31:0]       page_size,
    output logic [15:0]       sq_entry_bytes,
    output logic [15:0]       cq_entry_bytes,
    output logic [12:0]       admin_sq_depth,
    output logic [12:0]       admin_cq_depth,
    output logic [63:0]       admin_sq_base,
    output logic [63:0]       admin_cq_base
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [63:0] CAP_VALUE = {8'd0, 4'(MPS_MAX), 4'(MPS_MIN), 3'd0, 8'd1, 5'd0,
                                         8'(TIMEOUT), 7'd0, 1'b1, 16'(MQES)};

    logic [WORD_W-1:0] word;
    logic [31:0]       mask_q, cfg_q, attr_q;
    logic [63:0]       sqb_q, cqb_q;
    status_t           sts_q;
    logic              live_q, td_q;
    live_cfg_t         lcfg_q;

    logic [31:0] cfg_a, cfg_n;
    status_t     sts_n;
    logic        live_n, td_n, start_ok;
    logic        chk_ok;
    logic [4:0]  chk_pg;
    logic [31:0] rd_word;

    function automatic logic hit(input logic [WORD_W-1:0] w, input int idx);
        return w == WORD_W'(idx);
    endfunction

    assign word = addr[ADDR_W-1:2];

    hostctl_cfg_check #(
        .MPS_MIN(MPS_MIN), .MPS_MAX(MPS_MAX),
        .SQES_MIN(SQES_MIN), .SQES_MAX(SQES_MAX),
        .CQES_MIN(CQES_MIN), .CQES_MAX(CQES_MAX)
    ) u_check (
        .cfg_word   (wdata),
        .attr_word  (attr_q),
        .sq_base    (sqb_q),
        .cq_base    (cqb_q),
        .queues_live(live_q),
        .cfg_ok     (chk_ok),
        .pg_bits    (chk_pg)
    );

    hostctl_rd_mux #(.WORD_W(WORD_W)) u_rd (
        .word   (word),
        .cap    (CAP_VALUE),
        .mask   (mask_q),
        .cfg    (cfg_q),
        .sts    (sts_q),
        .attr   (attr_q),
        .sq_base(sqb_q),
        .cq_base(cqb_q),
        .data   (rd_word)
    );

    // enable edge first, then shutdown edge judged against the updated word
    always_comb begin
        cfg_a    = cfg_q;
        cfg_n    = cfg_q;
        sts_n    = sts_q;
        live_n   = live_q;
        td_n     = 1'b0;
        start_ok = 1'b0;
        if (wr_en && hit(word, WORD_CFG)) begin
            if (f_en(wdata) && !f_en(cfg_q)) begin
                cfg_a = wdata;
                if (chk_ok) begin
                    sts_n    = '{shst: 2'b00, fatal: 1'b0, ready: 1'b1};
                    live_n   = 1'b1;
                    start_ok = 1'b1;
                end else begin
                    sts_n = '{shst: 2'b00, fatal: 1'b1, ready: 1'b0};
                end
            end else if (!f_en(wdata) && f_en(cfg_q)) begin
                cfg_a       = 32'd0;
                live_n      = 1'b0;
                td_n        = 1'b1;
                sts_n.ready = 1'b0;
            end
            cfg_n = cfg_a;
            if ((f_shn(wdata) != 2'b00) && (f_shn(cfg_a) == 2'b00)) begin
                cfg_n      = wdata;
                live_n     = 1'b0;
                td_n       = 1'b1;
                sts_n.shst = SHST_DONE;
            end else if ((f_shn(wdata) == 2'b00) && (f_shn(cfg_a) != 2'b00)) begin
                cfg_n      = wdata;
                sts_n.shst = 2'b00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= 32'd0;
            cfg_q  <= 32'd0;
            attr_q <= 32'd0;
            sqb_q  <= 64'd0;
            cqb_q  <= 64'd0;
            sts_q  <= '0;
            live_q <= 1'b0;
            td_q   <= 1'b0;
            lcfg_q <= '0;
            rdata  <= 32'd0;
        end else begin
            if (wr_en && hit(word, WORD_MSET)) mask_q <= mask_q | wdata;
            if (wr_en && hit(word, WORD_MCLR)) mask_q <= mask_q & ~wdata;
            if (wr_en && hit(word, WORD_ATTR)) attr_q <= wdata;
            if (wr_en && hit(word, WORD_SQB_LO)) sqb_q <= {32'd0, wdata};
            if (wr_en && hit(word, WORD_SQB_HI)) sqb_q[63:32] <= sqb_q[63:32] | wdata;
            if (wr_en && hit(word, WORD_CQB_LO)) cqb_q <= {32'd0, wdata};
            if (wr_en && hit(word, WORD_CQB_HI)) cqb_q[63:32] <= cqb_q[63:32] | wdata;
            cfg_q  <= cfg_n;
            sts_q  <= sts_n;
            live_q <= live_n;
            td_q   <= td_n;
            if (start_ok) begin
                lcfg_q <= '{pg_bits: chk_pg,
                            sqes:    f_sqes(wdata),
                            cqes:    f_cqes(wdata),
                            asqs:    f_asqs(attr_q),
                            acqs:    f_acqs(attr_q),
                            sq_base: sqb_q,
                            cq_base: cqb_q};
            end
            if (rd_en) rdata <= rd_word;
        end
    end

    assign irq_mask       = mask_q;
    assign hc_ready       = sts_q.ready;
    assign hc_fatal       = sts_q.fatal;
    assign shdn_done      = (sts_q.shst == SHST_DONE);
    assign queues_live    = live_q;
    assign queue_teardown = td_q;
    assign page_bits      = lcfg_q.pg_bits;
    assign page_size      = 32'd1 << lcfg_q.pg_bits;
    assign sq_entry_bytes = 16'd1 << lcfg_q.sqes;
    assign cq_entry_bytes = 16'd1 << lcfg_q.cqes;
    assign admin_sq_depth = {1'b0, lcfg_q.asqs} + 13'd1;
    assign admin_cq_depth = {1'b0, lcfg_q.acqs} + 13'd1;
    assign admin_sq_base  = lcfg_q.sq_base;
    assign admin_cq_base  = lcfg_q.cq_base;
endmodule

// File: rtl/hostctl_regs_chk.sv
module hostctl_regs_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [31:0]       wdata,
    input logic [31:0]       irq_mask,
    input logic              hc_ready,
    input logic              hc_fatal,
    input logic              shdn_done,
    input logic              queues_live,
    input logic              queue_teardown,
    input logic [4:0]        page_bits,
    input logic [63:0]       admin_sq_base
);
    logic cfg_wr, mset_wr, mclr_wr;
    assign cfg_wr  = wr_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(5));
    assign mset_wr = wr_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(3));
    assign mclr_wr = wr_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(4));

    p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
        mset_wr |=> ((irq_mask & $past(wdata)) == $past(wdata)));

    p_mask_clr_r2: assert property (@(posedge clk) disable iff (rst)
        mclr_wr |=> ((irq_mask & $past(wdata)) == 32'd0));

    p_ready_needs_cfg_write_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(hc_ready) |-> $past(cfg_wr));

    p_ready_fatal_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(hc_ready && hc_fatal));

    p_base_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(hc_ready) |-> (admin_sq_base != 64'd0) &&
            ((admin_sq_base & ((64'd1 << page_bits) - 64'd1)) == 64'd0));

    p_live_needs_ready_r7: assert property (@(posedge clk) disable iff (rst)
        queues_live |-> hc_ready);

    p_teardown_stops_r7: assert property (@(posedge clk) disable iff (rst)
        queue_teardown |-> !queues_live);

    p_shdn_tears_down_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(shdn_done) |-> queue_teardown);
endmodule

bind hostctl_regs hostctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .addr          (addr),
    .wr_en         (wr_en),
    .wdata         (wdata),
    .irq_mask      (irq_mask),
    .hc_ready      (hc_ready),
    .hc_fatal      (hc_fatal),
    .shdn_done     (shdn_done),
    .queues_live   (queues_live),
    .queue_teardown(queue_teardown),
    .page_bits     (page_bits),
    .admin_sq_base (admin_sq_base)
);

// File: tb/sim_hostctl_regs.sv
module sim_hostctl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata, irq_mask, page_size;
    logic        hc_ready, hc_fatal, shdn_done, queues_live, queue_teardown;
    logic [4:0]  page_bits;
    logic [15:0] sq_entry_bytes, cq_entry_bytes;
    logic [12:0] admin_sq_depth, admin_cq_depth;
    logic [63:0] admin_sq_base, admin_cq_base;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_mask = 0, m_cfg = 0, m_attr = 0;
    logic [3:0]  m_sts = 0;
    logic [63:0] m_sqb = 0, m_cqb = 0, m_lsq = 0, m_lcq = 0;
    logic        m_live = 0, m_td = 0;
    int          m_pb = 0, m_sqes = 0, m_cqes = 0, m_asqs = 0, m_acqs = 0;

    hostctl_regs u0 (.*);

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int a);
        case (a)
            'h00: return 32'h0F01_07FF;
            'h04: return 32'h0040_0020;
            'h08: return 32'h0001_0001;
            'h0C, 'h10: return m_mask;
            'h14: return m_cfg;
            'h1C: return {28'd0, m_sts};
            'h24: return m_attr;
            'h28: return m_sqb[31:0];
            'h2C: return m_sqb[63:32];
            'h30: return m_cqb[31:0];
            'h34: return m_cqb[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_write(input int a, input logic [31:0] d);
        m_td = 0;
        case (a)
            'h0C: m_mask = m_mask | d;
            'h10: m_mask = m_mask & ~d;
            'h24: m_attr = d;
            'h28: m_sqb = {32'd0, d};
            'h2C: m_sqb[63:32] = m_sqb[63:32] | d;
            'h30: m_cqb = {32'd0, d};
            'h34: m_cqb[63:32] = m_cqb[63:32] | d;
            'h14: begin
                if (d[0] && !m_cfg[0]) begin
                    int pb = int'(d[10:7]) + 12;
                    logic [63:0] pg = 64'd1 << pb;
                    bit ok = !m_live && m_sqb != 0 && m_cqb != 0 &&
                             (m_sqb % pg) == 0 && (m_cqb % pg) == 0 &&
                             d[10:7] <= 4 && d[19:16] == 6 && d[23:20] == 4 &&
                             m_attr[11:0] != 0 && m_attr[27:16] != 0;
                    m_cfg = d;
                    if (ok) begin
                        m_sts = 4'b0001; m_live = 1;
                        m_pb = pb; m_sqes = 6; m_cqes = 4;
                        m_asqs = int'(m_attr[11:0]); m_acqs = int'(m_attr[27:16]);
                        m_lsq = m_sqb; m_lcq = m_cqb;
                    end else begin
                        m_sts = 4'b0010;
                    end
                end else if (!d[0] && m_cfg[0]) begin
                    m_cfg = 0; m_live = 0; m_td = 1; m_sts[0] = 0;
                end
                if (d[15:14] != 0 && m_cfg[15:14] == 0) begin
                    m_cfg = d; m_live = 0; m_td = 1; m_sts[3:2] = 2'b10;
                end else if (d[15:14] == 0 && m_cfg[15:14] != 0) begin
                    m_cfg = d; m_sts[3:2] = 2'b00;
                end
            end
            default: ;
        endcase
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 12'(a); wdata = d; wr_en = 1;
        @(posedge clk); #1;
        wr_en = 0;
        model_write(a, d);
        @(negedge clk); #1;
        m_td = 0;
    endtask

    task automatic rd(input int a, input string req);
        @(negedge clk);
        addr = 12'(a); rd_en = 1;
        @(posedge clk); #1;
        rd_en = 0;
        @(negedge clk); #1;
        check(req, $sformatf("read %0h", a), {32'd0, rdata}, {32'd0, m_read(a)});
    endtask

    task automatic chk_latched(input string req);
        check(req, "page_bits", {59'd0, page_bits}, 64'(m_pb));
        check(req, "page_size", {32'd0, page_size}, 64'd1 << m_pb);
        check(req, "sq_entry", {48'd0, sq_entry_bytes}, 64'd1 << m_sqes);
        check(req, "cq_entry", {48'd0, cq_entry_bytes}, 64'd1 << m_cqes);
        check(req, "sq_depth", {51'd0, admin_sq_depth}, 64'(m_asqs + 1));
        check(req, "cq_depth", {51'd0, admin_cq_depth}, 64'(m_acqs + 1));
        check(req, "sq_base", admin_sq_base, m_lsq);
        check(req, "cq_base", admin_cq_base, m_lcq);
    endtask

    // per-cycle comparison of the status-type outputs against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4", "ready", {63'd0, hc_ready}, {63'd0, m_sts[0]});
            check("R5", "fatal", {63'd0, hc_fatal}, {63'd0, m_sts[1]});
            check("R8", "shdn_done", {63'd0, shdn_done}, {63'd0, m_sts[3:2] == 2'b10});
            check("R2", "irq_mask", {32'd0, irq_mask}, {32'd0, m_mask});
            check("R7", "live", {63'd0, queues_live}, {63'd0, m_live});
            check("R7", "teardown", {63'd0, queue_teardown}, {63'd0, m_td});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    localparam logic [31:0] CFG_OK4K = 32'h0046_0001;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state and constants, R10 holes and beyond range
        rd('h00, "R1"); rd('h04, "R1"); rd('h08, "R1");
        rd('h14, "R1"); rd('h1C, "R1"); rd('h24, "R1"); rd('h2C, "R1");
        rd('h18, "R10"); rd('h38, "R10"); rd('h100, "R10");

        // R2 mask set / clear, both offsets
        wr('h0C, 32'h0000_F0F0); wr('h0C, 32'h0000_000F);
        rd('h0C, "R2"); rd('h10, "R2");
        wr('h10, 32'h0000_00F0);
        rd('h0C, "R2"); rd('h10, "R2");

        // R3 base low replace / high OR
        wr('h28, 32'h1234_5000); wr('h2C, 32'h1); wr('h2C, 32'h2);
        rd('h28, "R3"); rd('h2C, "R3");
        wr('h28, 32'h0010_0000);
        rd('h2C, "R3");
        wr('h30, 32'h0020_0000); wr('h34, 32'h0);
        rd('h30, "R3");

        // R5 zero size word fails
        wr('h14, CFG_OK4K);
        rd('h1C, "R5");
        wr('h14, 32'h0);
        rd('h14, "R7"); rd('h1C, "R7");

        // R4 valid enable
        wr('h24, 32'h001F_003F);
        wr('h14, CFG_OK4K);
        rd('h1C, "R4");
        chk_latched("R4");

        // R9 rewrites without edges keep the word
        wr('h14, 32'h0046_0081);
        rd('h14, "R9");
        wr('h14, CFG_OK4K | 32'h0000_0200);
        rd('h14, "R9");

        // R8 shutdown request and release
        wr('h14, 32'h0046_4001);
        rd('h14, "R8"); rd('h1C, "R8");
        wr('h14, 32'h0046_8001);
        rd('h14, "R9");
        wr('h14, CFG_OK4K);
        rd('h14, "R8"); rd('h1C, "R8");

        // R7 disable
        wr('h14, 32'h0);
        rd('h14, "R7"); rd('h1C, "R7");

        // R6 alignment follows programmed page size
        wr('h28, 32'h0010_1000);
        wr('h14, 32'h0046_0081);
        rd('h1C, "R6");
        wr('h14, 32'h0);
        wr('h14, CFG_OK4K);
        rd('h1C, "R6");
        chk_latched("R6");
        wr('h14, 32'h0);
        wr('h28, 32'h0010_2000); wr('h2C, 32'h0000_0004);
        wr('h14, 32'h0046_0081);
        rd('h1C, "R6");
        chk_latched("R6");
        wr('h14, 32'h0);

        // R5 individual failure causes
        wr('h14, 32'h0046_0281); rd('h1C, "R5"); wr('h14, 32'h0);
        wr('h14, 32'h0047_0001); rd('h1C, "R5"); wr('h14, 32'h0);
        wr('h14, 32'h0036_0001); rd('h1C, "R5"); wr('h14, 32'h0);
        wr('h30, 32'h0);
        wr('h14, CFG_OK4K); rd('h1C, "R5"); wr('h14, 32'h0);
        chk_latched("R5");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule